// File: doc/BRIEF.md
# Split Program/Data Memory Front End with Constant-Byte Path

This block sits between a small 8-bit core and its two private memories. Program storage and data storage are separate arrays, each behind its own port. The fetch port returns 16-bit program words. The data port reads and writes single bytes. Because the two ports share no storage and no bus, a fetch and a data access issued in the same cycle both finish on the following cycle. The fetch port is read-only, so no core-side port can change program storage. Each accepted fetch returns one word one cycle later. This lets the core fetch its next instruction while it executes the current one.

A third path lets the core read single bytes out of program storage and use them as read-only constants, for example tables or strings. The core gives a byte address. All of its bits except the lowest pick a program word, and the lowest bit picks which half of that word is returned. The result arrives after a fixed three-cycle handshake. While this read is in progress, the fetch port stops accepting requests. A request on the constant path has priority over a fetch offered in the same cycle.

The fetch and data ports use valid/ready handshakes, and each request is accepted in a cycle where valid and ready are both high. Fetch ready is pulled low in two cases: in any cycle where a constant read is requested, and for the following cycles until that read finishes. A fetch offered while ready is low is not taken, and the core must hold it. Data ready is high in every cycle after reset, so the data port never pushes back.

Top module: `hvd_mem_front`

## Requirements
- R1: While reset is held, `f_valid`, `d_rvalid`, `c_done` and `d_ready` are low.
- R2: A fetch accepted at a clock edge makes `f_valid` high for exactly the next cycle, with `f_word` equal to the program word at `f_addr`. A cycle with no accepted fetch makes `f_valid` low in the next cycle. Program word n holds (n * 40503 XOR 0x1D2B) mod 65536.
- R3: A data write stores `d_wdata` at `d_addr` and raises no `d_rvalid`. A data read accepted at an edge makes `d_rvalid` high in the next cycle, with `d_rdata` equal to the byte last written at that address.
- R4: A fetch and a data access accepted at the same edge both return their results in the next cycle.
- R5: `d_ready` is high in every cycle from the first cycle after reset is released.
- R6: On the constant path, `c_addr` bits above bit 0 select the program word. `c_addr[0]=0` returns bits 7:0 of that word, and `c_addr[0]=1` returns bits 15:8.
- R7: A constant request accepted in cycle T makes `c_done` high in cycle T+3 and only in that cycle, with `c_byte` valid there. A new request may be accepted in the cycle where `c_done` is high.
- R8: `f_ready` is low in the cycle of an accepted constant request and in the two cycles after it. `f_valid` is low in cycles T+1 to T+3.
- R9: A constant request made while a constant read is in progress is ignored. It produces no extra `c_done`, and the returned byte belongs to the first address.
- R10: Data-port writes never change program storage. Words fetched after any pattern of data writes still match the R2 formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_req | input | 1 | Fetch request valid |
| f_ready | output | 1 | Fetch port can accept a request |
| f_addr | input | 8 | Program word address to fetch |
| f_valid | output | 1 | Fetched word present on `f_word` |
| f_word | output | 16 | Fetched program word |
| d_valid | input | 1 | Data request valid |
| d_ready | output | 1 | Data port can accept a request |
| d_we | input | 1 | 1 = write, 0 = read |
| d_addr | input | 8 | Data byte address |
| d_wdata | input | 8 | Byte to write |
| d_rvalid | output | 1 | Read byte present on `d_rdata` |
| d_rdata | output | 8 | Byte read from data storage |
| c_req | input | 1 | Constant-byte read request |
| c_addr | input | 9 | Byte address into program storage |
| c_done | output | 1 | One-cycle pulse: constant byte ready |
| c_byte | output | 8 | Constant byte read from program storage |

## Verification
The hardest state to reach from the ports is a constant read that is already in flight while the core keeps pushing both a fetch and a second constant request at it. Three things are checked there: the stall, the ignore rule, and the acceptance of a new request in the done cycle. The bench sweeps every byte address of program storage back to back. Each next request is issued in the done cycle of the one before it, and a fetch is held pending the whole time. On odd addresses the bench also pushes a conflicting constant request into both busy cycles. The byte that comes back must still belong to the first address.

// File: rtl/hvd_pkg.sv
package hvd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CR_IDLE = 2'd0,
    CR_READ = 2'd1,
    CR_PICK = 2'd2
  } cread_state_e;
endpackage

// File: rtl/hvd_prog_store.sv
module hvd_prog_store #(
  parameter int unsigned PW  = 16,
  parameter int unsigned PAW = 8
) (
  input  logic           clk,
  input  logic           f_en,
  input  logic [PAW-1:0] f_addr,
  output logic [PW-1:0]  f_word_q,
  input  logic           c_en,
  input  logic [PAW-1:0] c_addr,
  output logic [PW-1:0]  c_word_q
);
  localparam int unsigned DEPTH = 1 << PAW;

  function automatic logic [PW-1:0] seed_word(input int unsigned idx);
    logic [31:0] prod;
    prod = 32'(idx) * 32'd40503;
    return PW'(prod ^ 32'h0000_1D2B);
  endfunction

  logic [PW-1:0] rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_fill
    assign rom[gi] = seed_word(gi);
  end

  // instruction read port
  always_ff @(posedge clk) begin
    if (f_en) f_word_q <= rom[f_addr];
  end

  // constant read port, independent of the fetch port
  always_ff @(posedge clk) begin
    if (c_en) c_word_q <= rom[c_addr];
  end
endmodule

// File: rtl/hvd_fetch_unit.sv
module hvd_fetch_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic f_req,
  input  logic c_req,
  input  logic c_busy,
  output logic f_ready,
  output logic f_fire,
  output logic f_valid
);
  logic valid_q;

  // constant path wins in its request cycle and while it runs
  assign f_ready = ~c_busy & ~c_req;
  assign f_fire  = f_req & f_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= f_fire;
  end

  assign f_valid = valid_q;
endmodule

// File: rtl/hvd_const_reader.sv
module hvd_const_reader
  import hvd_pkg::*;
#(
  parameter int unsigned PW  = 16,
  parameter int unsigned PAW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        c_req,
  input  logic [PAW+$clog2(PW/8)-1:0] c_addr,
  input  logic [PW-1:0]               rom_word,
  output logic                        rom_en,
  output logic [PAW-1:0]              rom_addr,
  output logic                        busy,
  output logic                        c_done,
  output logic [BYTE_W-1:0]           c_byte
);
  localparam int unsigned LANES = PW / BYTE_W;
  localparam int unsigned LSB   = $clog2(LANES);
  localparam int unsigned CAW   = PAW + LSB;

  cread_state_e        state_q;
  logic [CAW-1:0]      addr_q;
  logic                done_q;
  logic [BYTE_W-1:0]   byte_q;
  logic [BYTE_W-1:0]   lane_b [LANES];
  logic [LSB-1:0]      lane_sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_b[g] = rom_word[g*BYTE_W +: BYTE_W];
  end

  assign lane_sel = addr_q[LSB-1:0];
  assign rom_addr = addr_q[CAW-1:LSB];
  assign rom_en   = (state_q == CR_READ);
  assign busy     = (state_q != CR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CR_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CR_IDLE: begin
          if (c_req) begin
            addr_q  <= c_addr;
            state_q <= CR_READ;
          end
        end
        CR_READ: state_q <= CR_PICK;
        CR_PICK: begin
          byte_q  <= lane_b[lane_sel];
          done_q  <= 1'b1;
          state_q <= CR_IDLE;
        end
        default: state_q <= CR_IDLE;
      endcase
    end
  end

  assign c_done = done_q;
  assign c_byte = byte_q;
endmodule

// File: rtl/hvd_data_ram.sv
module hvd_data_ram
  import hvd_pkg::*;
#(
  parameter int unsigned DAW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  logic              d_we,
  input  logic [DAW-1:0]    d_addr,
  input  logic [BYTE_W-1:0] d_wdata,
  output logic              d_ready,
  output logic              d_rvalid,
  output logic [BYTE_W-1:0] d_rdata
);
  localparam int unsigned DEPTH = 1 << DAW;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              ready_q;
  logic              rvalid_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              fire;

  assign fire = d_valid & ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      ready_q  <= 1'b1;
      rvalid_q <= fire & ~d_we;
    end
  end

  always_ff @(posedge clk) begin
    if (fire & d_we)  mem[d_addr] <= d_wdata;
    if (fire & ~d_we) rdata_q     <= mem[d_addr];
  end

  assign d_ready  = ready_q;
  assign d_rvalid = rvalid_q;
  assign d_rdata  = rdata_q;
endmodule

// File: rtl/hvd_mem_front.sv
module hvd_mem_front
  import hvd_pkg::*;
#(
  parameter int unsigned PW  = 16,
  parameter int unsigned PAW = 8,
  parameter int unsigned DAW = 8,
  localparam int unsigned CAW = PAW + $clog2(PW / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_req,
  output logic              f_ready,
  input  logic [PAW-1:0]    f_addr,
  output logic              f_valid,
  output logic [PW-1:0]     f_word,
  input  logic              d_valid,
  output logic              d_ready,
  input  logic              d_we,
  input  logic [DAW-1:0]    d_addr,
  input  logic [BYTE_W-1:0] d_wdata,
  output logic              d_rvalid,
  output logic [BYTE_W-1:0] d_rdata,
  input  logic              c_req,
  input  logic [CAW-1:0]    c_addr,
  output logic              c_done,
  output logic [BYTE_W-1:0] c_byte
);
  logic           cr_busy;
  logic           cr_rom_en;
  logic [PAW-1:0] cr_rom_addr;
  logic [PW-1:0]  cr_rom_word;
  logic           fu_fire;

  hvd_fetch_unit u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .f_req   (f_req),
    .c_req   (c_req),
    .c_busy  (cr_busy),
    .f_ready (f_ready),
    .f_fire  (fu_fire),
    .f_valid (f_valid)
  );

  hvd_prog_store #(.PW(PW), .PAW(PAW)) u_prog (
    .clk      (clk),
    .f_en     (fu_fire),
    .f_addr   (f_addr),
    .f_word_q (f_word),
    .c_en     (cr_rom_en),
    .c_addr   (cr_rom_addr),
    .c_word_q (cr_rom_word)
  );

  hvd_const_reader #(.PW(PW), .PAW(PAW)) u_const (
    .clk      (clk),
    .rst_n    (rst_n),
    .c_req    (c_req),
    .c_addr   (c_addr),
    .rom_word (cr_rom_word),
    .rom_en   (cr_rom_en),
    .rom_addr (cr_rom_addr),
    .busy     (cr_busy),
    .c_done   (c_done),
    .c_byte   (c_byte)
  );

  hvd_data_ram #(.DAW(DAW)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_valid  (d_valid),
    .d_we     (d_we),
    .d_addr   (d_addr),
    .d_wdata  (d_wdata),
    .d_ready  (d_ready),
    .d_rvalid (d_rvalid),
    .d_rdata  (d_rdata)
  );
endmodule

// File: rtl/hvd_mem_front_chk.sv
module hvd_mem_front_chk (
  input logic clk,
  input logic rst_n,
  input logic f_req,
  input logic f_ready,
  input logic f_valid,
  input logic d_valid,
  input logic d_ready,
  input logic d_we,
  input logic d_rvalid,
  input logic c_req,
  input logic c_done,
  input logic c_busy
);
  assert_fetch_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && f_ready) |=> f_valid);

  assert_fetch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_req && f_ready) |=> !f_valid);

  assert_data_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_ready && !d_we) |=> d_rvalid);

  assert_data_write_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_valid && d_ready && !d_we) |=> !d_rvalid);

  assert_const_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req && !c_busy) |-> ##3 c_done);

  assert_const_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_done |=> !c_done);

  assert_stall_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_busy |-> !f_ready);

  assert_stall_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_busy |=> !f_valid);

  assert_no_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c_busy |-> !c_done);
endmodule

bind hvd_mem_front hvd_mem_front_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .f_req    (f_req),
  .f_ready  (f_ready),
  .f_valid  (f_valid),
  .d_valid  (d_valid),
  .d_ready  (d_ready),
  .d_we     (d_we),
  .d_rvalid (d_rvalid),
  .c_req    (c_req),
  .c_done   (c_done),
  .c_busy   (cr_busy)
);

// File: tb/hvd_mem_front_tb.sv
`timescale 1ns/1ps
module hvd_mem_front_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        f_req, f_ready, f_valid;
  logic [7:0]  f_addr;
  logic [15:0] f_word;
  logic        d_valid, d_ready, d_we, d_rvalid;
  logic [7:0]  d_addr, d_wdata, d_rdata;
  logic        c_req, c_done;
  logic [8:0]  c_addr;
  logic [7:0]  c_byte;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hvd_mem_front u_dut (
    .clk(clk), .rst_n(rst_n),
    .f_req(f_req), .f_ready(f_ready), .f_addr(f_addr), .f_valid(f_valid), .f_word(f_word),
    .d_valid(d_valid), .d_ready(d_ready), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_rvalid(d_rvalid), .d_rdata(d_rdata),
    .c_req(c_req), .c_addr(c_addr), .c_done(c_done), .c_byte(c_byte)
  );

  function automatic logic [15:0] pw(input int n);
    logic [31:0] p;
    p = 32'(n) * 32'd40503;
    return p[15:0] ^ 16'h1D2B;
  endfunction

  function automatic logic [7:0] dv(input int n);
    logic [31:0] p;
    p = 32'(n) * 32'd29 + 32'd7;
    return p[7:0];
  endfunction

  function automatic logic [7:0] cb(input int a);
    logic [15:0] w;
    w = pw(a >> 1);
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    f_req = 0; f_addr = 0; d_valid = 0; d_we = 0; d_addr = 0; d_wdata = 0;
    c_req = 0; c_addr = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 f_valid", f_valid, 0);
    chk("R1 d_rvalid", d_rvalid, 0);
    chk("R1 c_done", c_done, 0);
    chk("R1 d_ready", d_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 d_ready", d_ready, 1);
    chk("R8 f_ready idle", f_ready, 1);

    // write sweep with concurrent fetch (R2, R3, R4)
    for (int i = 0; i <= 256; i++) begin
      if (i > 0) begin
        chk("R4 f_valid", f_valid, 1);
        chk("R2 f_word", f_word, pw(i - 1));
        chk("R3 no rvalid on write", d_rvalid, 0);
        chk("R5 d_ready", d_ready, 1);
      end
      if (i < 256) begin
        f_req = 1; f_addr = 8'(i);
        d_valid = 1; d_we = 1; d_addr = 8'(i); d_wdata = dv(i);
      end else begin
        f_req = 0; d_valid = 0; d_we = 0;
      end
      @(negedge clk);
    end
    chk("R2 f_valid idle", f_valid, 0);

    // read sweep with concurrent fetch of other words (R3, R4, R10)
    for (int i = 0; i <= 256; i++) begin
      if (i > 0) begin
        chk("R4 d_rvalid", d_rvalid, 1);
        chk("R3 d_rdata", d_rdata, dv(i - 1));
        chk("R4 f_valid", f_valid, 1);
        chk("R10 f_word", f_word, pw((i - 1) ^ 8'hA5));
      end
      if (i < 256) begin
        f_req = 1; f_addr = 8'(i ^ 8'hA5);
        d_valid = 1; d_we = 0; d_addr = 8'(i);
      end else begin
        f_req = 0; d_valid = 0;
      end
      @(negedge clk);
    end
    chk("R3 rvalid idle", d_rvalid, 0);
    chk("R2 f_valid idle", f_valid, 0);

    // constant-byte sweep, back to back, fetch held pending (R6..R9)
    for (int a = 0; a < 512; a++) begin
      if (a > 0) begin
        chk("R7 c_done", c_done, 1);
        chk("R6 c_byte", c_byte, cb(a - 1));
        chk("R8 f_valid T+3", f_valid, 0);
      end
      c_req = 1; c_addr = 9'(a);
      f_req = 1; f_addr = 8'(a >> 1);
      #1;
      chk("R8 f_ready T", f_ready, 0);
      @(negedge clk);
      chk("R7 no early done", c_done, 0);
      chk("R8 f_valid T+1", f_valid, 0);
      c_req = a[0];
      c_addr = 9'(~a);
      #1;
      chk("R8 f_ready T+1", f_ready, 0);
      @(negedge clk);
      chk("R9 no done while busy", c_done, 0);
      chk("R8 f_valid T+2", f_valid, 0);
      #1;
      chk("R8 f_ready T+2", f_ready, 0);
      @(negedge clk);
    end
    chk("R7 c_done last", c_done, 1);
    chk("R6 c_byte last", c_byte, cb(511));
    c_req = 0; f_req = 1; f_addr = 8'h3C;
    #1;
    chk("R8 f_ready after done", f_ready, 1);
    @(negedge clk);
    chk("R7 pulse width", c_done, 0);
    chk("R8 fetch resumes", f_valid, 1);
    chk("R10 f_word", f_word, pw(8'h3C));
    f_req = 0;
    @(negedge clk);
    chk("R2 f_valid idle", f_valid, 0);
    chk("R7 no spurious done", c_done, 0);
    finish_run();
  end
endmodule